// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block orders the bring-up and shut-down of an LCD panel interface in three stages: the pixel clock enable, the horizontal/vertical sync enable, and the panel power line. Software drives one-cycle write-one strobes. Each stage has its own enable strobe and its own disable strobe. For each stage a status bit shows the real state of that stage's output, so software can poll it before it moves to the next step.

Power-up runs clock, then sync, then panel power. Power-down runs in the reverse order. A strobe that would break this order is dropped. The panel power line is not raised as soon as software asks for it. It waits for a programmable number of frame-start ticks from the timing generator. This gives the panel a guard time with sync running before it is powered. The block only drives the three enables. The sync waveforms, the pixel data and the clock divider are outside it.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While rst_ni is low, and after it is released until a strobe arrives, all six outputs are low.
- R2: A clock enable strobe sets pix_clk_en_o at the next clock edge. stat_clk_o follows pix_clk_en_o one cycle later, on both rise and fall.
- R3: A sync enable strobe is honoured only while both pix_clk_en_o and stat_clk_o are high. Otherwise it is ignored. stat_sync_o follows sync_en_o one cycle later.
- R4: A panel power enable strobe arms the guard counter only while both sync_en_o and stat_sync_o are high. Otherwise it is ignored.
- R5: With guard value G, disp_o and stat_disp_o rise together at the clock edge after the (G+1)-th frame tick that follows the arming cycle. G = 0 therefore powers the panel on the first frame tick.
- R6: A panel power disable strobe clears disp_o at the next edge. If the guard count is still running, the strobe cancels the pending assertion and clears the counter, so a later arm restarts the full count.
- R7: A sync disable strobe is ignored while disp_o is high or a guard count is pending. Otherwise it clears sync_en_o at the next edge.
- R8: A clock disable strobe is ignored while sync_en_o or stat_sync_o is high.
- R9: When a stage's enable and disable strobes arrive in the same cycle, the disable takes priority. An enable strobe while the stage is already on or pending changes nothing, including a running guard count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_on_i | input | 1 | Write-one strobe: enable pixel clock |
| sync_on_i | input | 1 | Write-one strobe: enable sync outputs |
| disp_on_i | input | 1 | Write-one strobe: request panel power |
| clk_off_i | input | 1 | Write-one strobe: disable pixel clock |
| sync_off_i | input | 1 | Write-one strobe: disable sync outputs |
| disp_off_i | input | 1 | Write-one strobe: remove panel power |
| guard_i | input | GUARD_W | Frames to wait, minus one, before panel power |
| frame_tick_i | input | 1 | One-cycle frame-start pulse from timing generator |
| pix_clk_en_o | output | 1 | Pixel clock enable |
| sync_en_o | output | 1 | Sync output enable |
| disp_o | output | 1 | Panel power line |
| stat_clk_o | output | 1 | Status: clock running |
| stat_sync_o | output | 1 | Status: sync active |
| stat_disp_o | output | 1 | Status: panel power active |

## Verification
The guard count is swept over every value from 0 to 7. For each value the bench checks panel power after every frame tick, so a count that ends one tick early or one tick late shows up at once. Strobes are also sent in the wrong order, which separates honoured strobes from ignored ones: sync before clock, panel power before sync status, clock disable with sync on, and sync disable while the count is pending. Cancel-then-re-arm shows whether the counter was cleared. A repeated arm during a count shows whether the count restarts, and an enable sent together with its disable checks which one has priority.

// File: rtl/lcdps_pkg.sv
package lcdps_pkg;
  typedef enum logic [1:0] {
    DS_OFF   = 2'd0,
    DS_ARMED = 2'd1,
    DS_ON    = 2'd2
  } disp_state_e;
endpackage

// File: rtl/lcdps_stage.sv
// Generic on/off stage with gated enable, blocked disable and a lagging status.
module lcdps_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic off_i,
  input  logic allow_on_i,
  input  logic block_off_i,
  output logic en_o,
  output logic stat_o
);
  logic en_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      stat_q <= en_q;
      if (off_i) begin
        if (!block_off_i) en_q <= 1'b0;
      end else if (on_i && allow_on_i) begin
        en_q <= 1'b1;
      end
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/lcdps_disp.sv
// Panel power stage with frame-counted guard time.
module lcdps_disp
  import lcdps_pkg::*;
#(
  parameter int GUARD_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               on_i,
  input  logic               off_i,
  input  logic               allow_on_i,
  input  logic               tick_i,
  input  logic [GUARD_W-1:0] guard_i,
  output logic               disp_o,
  output logic               pending_o
);
  disp_state_e        st_q, st_d;
  logic [GUARD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      DS_OFF: begin
        if (on_i && !off_i && allow_on_i) begin
          st_d  = DS_ARMED;
          cnt_d = '0;
        end
      end
      DS_ARMED: begin
        if (off_i) begin
          st_d  = DS_OFF;
          cnt_d = '0;
        end else if (tick_i) begin
          // >= so a guard lowered mid-count still terminates
          if (cnt_q >= guard_i) begin
            st_d  = DS_ON;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      DS_ON: begin
        if (off_i) st_d = DS_OFF;
      end
      default: begin
        st_d  = DS_OFF;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DS_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign disp_o    = (st_q == DS_ON);
  assign pending_o = (st_q == DS_ARMED);
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int GUARD_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_on_i,
  input  logic               sync_on_i,
  input  logic               disp_on_i,
  input  logic               clk_off_i,
  input  logic               sync_off_i,
  input  logic               disp_off_i,
  input  logic [GUARD_W-1:0] guard_i,
  input  logic               frame_tick_i,
  output logic               pix_clk_en_o,
  output logic               sync_en_o,
  output logic               disp_o,
  output logic               stat_clk_o,
  output logic               stat_sync_o,
  output logic               stat_disp_o
);
  logic clk_en, clk_st, sync_en, sync_st, disp_on, disp_pend;

  lcdps_stage u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .on_i        (clk_on_i),
    .off_i       (clk_off_i),
    .allow_on_i  (1'b1),
    .block_off_i (sync_en | sync_st),
    .en_o        (clk_en),
    .stat_o      (clk_st)
  );

  lcdps_stage u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .on_i        (sync_on_i),
    .off_i       (sync_off_i),
    .allow_on_i  (clk_en & clk_st),
    .block_off_i (disp_on | disp_pend),
    .en_o        (sync_en),
    .stat_o      (sync_st)
  );

  lcdps_disp #(.GUARD_W(GUARD_W)) u_disp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .on_i       (disp_on_i),
    .off_i      (disp_off_i),
    .allow_on_i (sync_en & sync_st),
    .tick_i     (frame_tick_i),
    .guard_i    (guard_i),
    .disp_o     (disp_on),
    .pending_o  (disp_pend)
  );

  assign pix_clk_en_o = clk_en;
  assign stat_clk_o   = clk_st;
  assign sync_en_o    = sync_en;
  assign stat_sync_o  = sync_st;
  assign disp_o       = disp_on;
  assign stat_disp_o  = disp_on;
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_on_i,
  input logic disp_off_i,
  input logic frame_tick_i,
  input logic pix_clk_en_o,
  input logic sync_en_o,
  input logic disp_o,
  input logic stat_clk_o,
  input logic stat_sync_o
);
  AST_SYNC_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_o |-> pix_clk_en_o); // R8
  AST_DISP_NEEDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_o |-> sync_en_o); // R7
  AST_CLK_STAT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clk_o == $past(pix_clk_en_o)); // R2
  AST_SYNC_RISE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_en_o) |-> $past(sync_on_i && stat_clk_o)); // R3
  AST_SYNC_STAT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_sync_o == $past(sync_en_o)); // R3
  AST_DISP_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disp_o) |-> $past(frame_tick_i && stat_sync_o)); // R5
  AST_DISP_FALL_ON_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(disp_o) |-> $past(disp_off_i)); // R6
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_on_i    (sync_on_i),
  .disp_off_i   (disp_off_i),
  .frame_tick_i (frame_tick_i),
  .pix_clk_en_o (pix_clk_en_o),
  .sync_en_o    (sync_en_o),
  .disp_o       (disp_o),
  .stat_clk_o   (stat_clk_o),
  .stat_sync_o  (stat_sync_o)
);

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_on = 0, sync_on = 0, disp_on = 0;
  logic clk_off = 0, sync_off = 0, disp_off = 0;
  logic tick = 0;
  logic [GW-1:0] guard = '0;
  logic pix_clk_en, sync_en, disp, st_clk, st_sync, st_disp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_pwr_seq #(.GUARD_W(GW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .clk_on_i(clk_on), .sync_on_i(sync_on), .disp_on_i(disp_on),
    .clk_off_i(clk_off), .sync_off_i(sync_off), .disp_off_i(disp_off),
    .guard_i(guard), .frame_tick_i(tick),
    .pix_clk_en_o(pix_clk_en), .sync_en_o(sync_en), .disp_o(disp),
    .stat_clk_o(st_clk), .stat_sync_o(st_sync), .stat_disp_o(st_disp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // 0:clk_on 1:sync_on 2:disp_on 3:clk_off 4:sync_off 5:disp_off 6:tick
  task automatic pulse(input logic [6:0] m);
    {tick, disp_off, sync_off, clk_off, disp_on, sync_on, clk_on} = m;
    @(negedge clk);
    {tick, disp_off, sync_off, clk_off, disp_on, sync_on, clk_on} = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic bring_sync();
    pulse(7'b0000001); idle(1);
    pulse(7'b0000010); idle(1);
  endtask

  task automatic frame();
    pulse(7'b1000000);
  endtask

  initial begin
    idle(1);
    chk("R1 clk", pix_clk_en, 0); chk("R1 sync", sync_en, 0); chk("R1 disp", disp, 0);
    chk("R1 sclk", st_clk, 0); chk("R1 ssync", st_sync, 0); chk("R1 sdisp", st_disp, 0);
    do_reset();
    chk("R1 after release", pix_clk_en | sync_en | disp | st_clk | st_sync | st_disp, 0);

    // R3: sync before clock is ignored
    pulse(7'b0000010);
    chk("R3 sync w/o clk", sync_en, 0);
    // R4: disp before sync is ignored
    pulse(7'b0000100); frame(); frame();
    chk("R4 disp w/o sync", disp, 0);
    // R9: enable+disable same cycle on clock
    pulse(7'b0001001);
    chk("R9 clk dis wins", pix_clk_en, 0);
    // R2
    pulse(7'b0000001);
    chk("R2 clk en", pix_clk_en, 1);
    chk("R2 stat lag", st_clk, 0);
    idle(1);
    chk("R2 stat up", st_clk, 1);
    // R3: sync on and status lag
    pulse(7'b0000010);
    chk("R3 sync en", sync_en, 1);
    chk("R3 sync stat lag", st_sync, 0);
    // R8: clock disable blocked
    pulse(7'b0001000);
    chk("R8 clk kept", pix_clk_en, 1);
    chk("R3 sync stat up", st_sync, 1);

    // R5 sweep over guard values
    for (int g = 0; g < 8; g++) begin
      guard = GW'(g);
      pulse(7'b0000100);
      chk("R5 not yet on arm", disp, 0);
      for (int k = 1; k <= g + 1; k++) begin
        frame();
        chk("R5 disp", disp, (k == g + 1));
        chk("R5 stat", st_disp, (k == g + 1));
        if (k == 1 && g > 0) begin
          pulse(7'b0010000);
          chk("R7 sync kept pending", sync_en, 1);
        end
      end
      pulse(7'b0010000);
      chk("R7 sync kept on", sync_en, 1);
      pulse(7'b0100000);
      chk("R6 disp off", disp, 0);
      chk("R6 stat off", st_disp, 0);
    end

    // R6: cancel during count, then full re-arm
    guard = 4'd3;
    pulse(7'b0000100); frame(); frame();
    pulse(7'b0100000);
    frame(); frame(); frame();
    chk("R6 cancelled", disp, 0);
    pulse(7'b0000100);
    frame(); frame(); frame();
    chk("R6 counter cleared", disp, 0);
    frame();
    chk("R6 rearm done", disp, 1);
    pulse(7'b0100000);

    // R9: repeat enable while armed leaves count alone
    guard = 4'd2;
    pulse(7'b0000100); frame(); frame();
    pulse(7'b0000100);
    frame();
    chk("R9 no restart", disp, 1);
    // R9: disable wins on disp
    pulse(7'b0100100);
    chk("R9 disp dis wins", disp, 0);
    pulse(7'b1000000);
    chk("R9 not rearmed", disp, 0);

    // Power-down order
    pulse(7'b0010000);
    chk("R7 sync off", sync_en, 0);
    pulse(7'b0001000);
    chk("R8 clk blocked by sync stat", pix_clk_en, 1);
    pulse(7'b0000010);
    chk("R3 sync re-on", sync_en, 1);
    pulse(7'b0010000); idle(1);
    pulse(7'b0001000);
    chk("R2 clk off", pix_clk_en, 0);
    chk("R2 stat still up", st_clk, 1);
    pulse(7'b0000010);
    chk("R3 sync ignored stat lag", sync_en, 0);
    chk("R2 stat down", st_clk, 0);

    // Reset mid-operation
    bring_sync();
    do_reset();
    chk("R1 reset clears", pix_clk_en | sync_en | disp | st_clk | st_sync, 0);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule